// File: doc/BRIEF.md
# High-Phase Doubling Pulse Stretcher

This block watches a single-bit pulse train that repeats, or nearly repeats, and produces a second pulse train from it. Each high phase of the output is twice as long as the last high run measured on the input. Each low phase of the output is as long as the last low run measured on the input. Both lengths are counted in clock cycles. A measurement unit finds the input edges. It counts how long the input stays high and how long it stays low, and it keeps the most recent completed value of each count. A regeneration unit then plays the output back from those stored values. A new measurement takes effect only when the output finishes its current phase.

After reset, no high run has been measured yet. Until the input's first falling edge, the output therefore follows the input directly, so the first output rising edge lines up with the input. At that first falling edge the output stays high long enough to double the first high run. After that the regeneration unit drives the output on its own. The input must be periodic or close to it: the output period is longer than the input period, and the block keeps only the latest pair of counts.

Top module: `hpd_stretcher`

## Requirements
- R1: While `rst_n` is low and `pulse_in` is low, `pulse_out` is low. After reset is released, `pulse_out` stays low for as long as `pulse_in` stays low.
- R2: Every output high phase after the first lasts 2×N cycles. N is the input high run length that was latched at the most recent input falling edge before that phase began.
- R3: Every output low phase lasts M cycles, or 1 cycle if M is 0. M is the input low run length that was latched at the most recent input rising edge before that phase began. Before the first rising edge, the low count runs from the release of reset. For a steady pattern, the output low phases equal the input low run.
- R4: The high count starts at 1 in the cycle of an input rising edge and is latched when the input falls. The low count starts at 1 in the cycle of an input falling edge and is latched when the input rises.
- R5: Until the first input falling edge, `pulse_out` equals `pulse_in`, rising in the same cycle as the input. The output also stays high in the falling-edge cycle itself. The first output high phase lasts H + min(H, 2^CNT_W−1) cycles, where H is the first input high run. It is followed by an output low phase.
- R6: The counts saturate at 2^CNT_W−1 instead of wrapping. With CNT_W = 8, a steady pattern of 300 cycles high and 300 cycles low gives output high phases of 510 cycles and low phases of 255 cycles.
- R7: A phase that has started is never shortened or lengthened when the measured counts change. Across a change of input pattern, every output high phase equals twice one of the latched high counts, and every low phase equals one of the latched low counts.
- R8: Asserting reset during operation forces `pulse_out` low at once (with `pulse_in` low) and restores pass-through. After release, the output again follows the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| pulse_in | input | 1 | Quasi-periodic input pulse train |
| pulse_out | output | 1 | Regenerated output: high phases doubled, low phases kept |

## Verification
A stuck or corrupted count shows up at the output as one wrong phase length. A high count that wrapped instead of saturating is the clearest case: it gives a short high phase instead of 510 cycles. This error appears within one output period of the faulty measurement. An error in the first-pass state shows in the very first output rise, as a missing alignment with the input or a wrong length for the first high phase. A count loaded in the middle of a phase shows as a phase length that matches no latched value, so the bench checks every phase across a change of pattern against the set of values that are allowed.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  // Output phase of the regeneration unit
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/hpd_meter.sv
// Measures high and low run lengths of the input and holds the last completed ones.
module hpd_meter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  output logic         pin_q,
  output logic         rise,
  output logic         fall,
  output logic         first_pass,
  output logic [W-1:0] hi_cnt,
  output logic [W-1:0] hi_len,
  output logic [W-1:0] lo_len
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] lo_cnt;
  logic [W-1:0] hi_cnt_n, lo_cnt_n;
  logic         hi_en, lo_en;

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;

  // next-state and clock enables
  always_comb begin
    hi_en    = rise | (pin & pin_q & (hi_cnt != CMAX));
    hi_cnt_n = rise ? ONE : hi_cnt + ONE;
    lo_en    = fall | (~pin & ~pin_q & (lo_cnt != CMAX));
    lo_cnt_n = fall ? ONE : lo_cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q      <= 1'b0;
      first_pass <= 1'b1;
      hi_cnt     <= '0;
      lo_cnt     <= '0;
      hi_len     <= '0;
      lo_len     <= '0;
    end else begin
      pin_q <= pin;
      if (hi_en) hi_cnt <= hi_cnt_n;
      if (lo_en) lo_cnt <= lo_cnt_n;
      if (fall)  hi_len <= hi_cnt;
      if (rise)  lo_len <= lo_cnt;
      if (fall)  first_pass <= 1'b0;
    end
  end

  // R6: a saturated high count holds while the input stays high
  p_hi_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt == CMAX && pin && pin_q) |=> (hi_cnt == CMAX));
  // R6: same for the low count
  p_lo_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt == CMAX && !pin && !pin_q) |=> (lo_cnt == CMAX));
  // R4: the latched high length changes only on a falling edge
  p_hi_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(hi_len));
  // R5: pass-through never comes back without a reset
  p_first_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !first_pass |=> !first_pass);
endmodule

// File: rtl/hpd_regen.sv
// Plays back output phases from the latched counts; loads only at phase ends.
module hpd_regen
  import hpd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         first_pass,
  input  logic         fall,
  input  logic [W-1:0] hi_cnt,
  input  logic [W-1:0] hi_len,
  input  logic [W-1:0] lo_len,
  output logic         gen_out
);
  localparam int RW = W + 1;
  localparam logic [RW-1:0] R_ONE = RW'(1);

  phase_e        ph, ph_n;
  logic [RW-1:0] rem, rem_n;
  logic          step_en;
  logic [RW-1:0] hi_span, lo_span, first_ext;

  assign hi_span   = {hi_len, 1'b0};
  assign lo_span   = (lo_len == '0) ? R_ONE : {1'b0, lo_len};
  assign first_ext = {1'b0, hi_cnt} - R_ONE;

  always_comb begin
    ph_n    = ph;
    rem_n   = rem;
    step_en = 1'b0;
    if (first_pass) begin
      if (fall) begin
        step_en = 1'b1;
        if (hi_cnt == W'(1)) begin
          ph_n  = PH_LOW;
          rem_n = lo_span;
        end else begin
          ph_n  = PH_HIGH;
          rem_n = first_ext;
        end
      end
    end else begin
      step_en = 1'b1;
      if (rem == R_ONE) begin
        if (ph == PH_HIGH) begin
          ph_n  = PH_LOW;
          rem_n = lo_span;
        end else begin
          ph_n  = PH_HIGH;
          rem_n = hi_span;
        end
      end else begin
        rem_n = rem - R_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_LOW;
      rem <= '0;
    end else if (step_en) begin
      ph  <= ph_n;
      rem <= rem_n;
    end
  end

  assign gen_out = (ph == PH_HIGH);

  // R7: a phase with cycles left keeps its level
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_pass && rem > R_ONE) |=> (ph == $past(ph)));
  // R2: the last cycle of a phase is followed by the other level
  p_phase_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_pass && rem == R_ONE) |=> (ph != $past(ph)));
  // R2: a new high phase takes twice the latched high count
  p_hi_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_pass && rem == R_ONE && ph == PH_LOW) |=> (rem == $past({hi_len, 1'b0})));
  // R3: a low phase never starts empty
  p_lo_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_pass && rem == R_ONE && ph == PH_HIGH) |=> (rem != '0));
endmodule

// File: rtl/hpd_stretcher.sv
module hpd_stretcher #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_out
);
  logic             pin_q, rise, fall, first_pass, gen_out;
  logic [CNT_W-1:0] hi_cnt, hi_len, lo_len;

  hpd_meter #(.W(CNT_W)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin       (pulse_in),
    .pin_q     (pin_q),
    .rise      (rise),
    .fall      (fall),
    .first_pass(first_pass),
    .hi_cnt    (hi_cnt),
    .hi_len    (hi_len),
    .lo_len    (lo_len)
  );

  hpd_regen #(.W(CNT_W)) u_regen (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_pass(first_pass),
    .fall      (fall),
    .hi_cnt    (hi_cnt),
    .hi_len    (hi_len),
    .lo_len    (lo_len),
    .gen_out   (gen_out)
  );

  // pass-through holds high through the first falling-edge cycle
  assign pulse_out = first_pass ? (pulse_in | pin_q) : gen_out;

  // R5: the first output rise lines up with the input rise
  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (first_pass && rise) |-> pulse_out);
  // R5: the first falling-edge cycle keeps the output high
  p_fall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (first_pass && fall) |-> pulse_out);
endmodule

// File: tb/tb_hpd_stretcher.sv
`timescale 1ns/1ps
module tb_hpd_stretcher;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic pout;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hpd_stretcher #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pin), .pulse_out(pout)
  );

  // run-length monitor, sampled 1 ns before each rising edge
  int   rl[$];
  int   rv[$];
  logic cur = 1'b0;
  int   clen = 0;
  always @(negedge clk) begin
    #3;
    if (!rst_n) begin
      cur = 1'b0;
      clen = 0;
    end else if (pout === cur) begin
      clen++;
    end else begin
      rl.push_back(clen);
      rv.push_back(int'(cur));
      cur = pout;
      clen = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic hold(input logic lvl, input int n);
    pin = lvl;
    repeat (n) @(negedge clk);
  endtask

  // R1: reset state; leaves the bench at a falling clock edge with reset released
  task automatic do_reset();
    pin = 1'b0;
    rst_n = 1'b0;
    #1 chk(pout == 1'b0, "R1 reset low", int'(pout), 0);
    repeat (3) @(negedge clk);
    chk(pout == 1'b0, "R1 reset held", int'(pout), 0);
    rst_n = 1'b1;
    rl.delete();
    rv.delete();
  endtask

  task automatic exp_run(input int idx, input int lvl, input int len, input string req);
    if (idx >= rl.size()) chk(1'b0, req, -1, len);
    else chk(rv[idx] == lvl && rl[idx] == len, req, rl[idx], len);
  endtask

  // steady periodic pattern: h cycles high, l cycles low
  task automatic t_steady(input int h, input int l, input int nper,
                          input int e_first, input int e_hi, input int e_lo);
    do_reset();
    pin = 1'b0;
    repeat (l - 1) @(negedge clk);
    #3 chk(pout == 1'b0, "R1 low after release", int'(pout), 0);
    @(negedge clk);
    pin = 1'b1;
    #3 chk(pout == 1'b1, "R5 aligned first rise", int'(pout), 1);
    repeat (h) @(negedge clk);
    hold(1'b0, l);
    for (int p = 1; p < nper; p++) begin
      hold(1'b1, h);
      hold(1'b0, l);
    end
    exp_run(0, 0, l, "R1 initial low run");
    exp_run(1, 1, e_first, "R5 first high phase");
    exp_run(2, 0, e_lo, "R3 low phase 1");
    exp_run(3, 1, e_hi, "R2 high phase 2");
    exp_run(4, 0, e_lo, "R3 R4 low phase 2");
    exp_run(5, 1, e_hi, "R2 R4 high phase 3");
    exp_run(6, 0, e_lo, "R3 low phase 3");
  endtask

  // R7: pattern change from 3/3 to 6/2
  task automatic t_change();
    do_reset();
    hold(1'b0, 3);
    for (int p = 0; p < 6; p++) begin hold(1'b1, 3); hold(1'b0, 3); end
    for (int p = 0; p < 12; p++) begin hold(1'b1, 6); hold(1'b0, 2); end
    chk(rl.size() >= 10, "R7 enough phases", rl.size(), 10);
    exp_run(1, 1, 6, "R5 first high after change test start");
    for (int i = 2; i < rl.size(); i++) begin
      if (rv[i] == 1) chk(rl[i] == 6 || rl[i] == 12, "R7 R2 high phase in set", rl[i], 12);
      else chk(rl[i] == 3 || rl[i] == 2, "R7 R3 low phase in set", rl[i], 2);
    end
    if (rl.size() >= 2) begin
      int last = rl.size() - 1;
      int prev = last - 1;
      int hi_i = (rv[last] == 1) ? last : prev;
      int lo_i = (rv[last] == 0) ? last : prev;
      chk(rl[hi_i] == 12, "R2 new high count used", rl[hi_i], 12);
      chk(rl[lo_i] == 2, "R3 new low count used", rl[lo_i], 2);
    end
  endtask

  // R8: reset during operation
  task automatic t_reset_mid();
    do_reset();
    hold(1'b0, 3);
    hold(1'b1, 4);
    hold(1'b0, 4);
    hold(1'b1, 4);
    hold(1'b0, 2);
    pin = 1'b0;
    rst_n = 1'b0;
    #1 chk(pout == 1'b0, "R8 output low at reset", int'(pout), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3 chk(pout == 1'b0, "R8 low after release", int'(pout), 0);
    @(negedge clk);
    pin = 1'b1;
    #3 chk(pout == 1'b1, "R8 pass-through again", int'(pout), 1);
    @(negedge clk);
    pin = 1'b0;
    #3 chk(pout == 1'b1, "R5 fall cycle held high", int'(pout), 1);
    @(negedge clk);
    #3 chk(pout == 1'b0, "R5 low after 1+1 high", int'(pout), 0);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_steady(3, 4, 10, 6, 6, 4);        // R2 R3 basic
    t_steady(5, 2, 10, 10, 10, 2);      // R2 R3 low shorter than high
    t_steady(1, 1, 10, 2, 2, 1);        // R2 R3 minimum runs
    t_steady(300, 300, 8, 555, 510, 255); // R6 saturation
    t_change();                          // R7
    t_reset_mid();                       // R8
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
    end
  end
endmodule